// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a list of transmit descriptors that software keeps in system memory. It reads them through a single-word memory port that can both read and write. Each descriptor is four 32-bit words. Word 0 carries the ownership flag and, after transmission, the completion status. Word 1 carries the control flags and the buffer size. Word 2 points at the frame buffer, and word 3 links to the next descriptor when chaining is selected. For every descriptor it owns, the engine passes the buffer pointer, length and frame flags to a downstream data mover. It then waits for that mover's completion report, writes the status back into word 0 with ownership returned to software, and optionally raises an interrupt.

Software programs the ring base while the engine is stopped and then sets the run control. The engine follows one of three rules to reach the next descriptor: the link word when chaining is selected, the ring base when the end-of-ring flag is set, and otherwise the next 16-byte slot. If the engine reads a descriptor that software has not handed over, it raises a buffer-unavailable flag and suspends. A poll-demand strobe makes it fetch that same descriptor again. Clearing the run control lets the frame in progress finish, and the engine stops after it.

Top module: `txdesc_ring_engine`

## Requirements
- R1: After synchronous reset the engine is stopped. `mem_req`, `mv_valid`, `irq` and `buf_unavail` are all 0.
- R2: On start the engine reads from the ring base. Every descriptor is read word by word at offsets 0, 4 and 8, and at offset 12 only when the chained flag (word 1 bit 24) is set. A memory request holds its address and direction until `mem_ack`.
- R3: A word 0 read with bit 31 clear starts no transfer. It sets `buf_unavail` and suspends the engine with no further memory request. Writing 1 to `unavail_clr` clears the flag.
- R4: A `cfg_poll` pulse while suspended re-reads word 0 of the same descriptor.
- R5: The mover request carries the following, held until `mv_ready`:
  - word 2 as the address;
  - word 1 bits 10:0 as the length;
  - bit 29 as first and bit 30 as last;
  - bits 28:27 as the checksum control;
  - bit 26 as the no-CRC flag.
- R6: After `cpl_valid` the engine writes word 0 once. In the written value:
  - bit 31 is 0 (ownership returned to software);
  - bit 1 is underflow, bit 9 is late collision and bit 8 is excessive collision;
  - bits 6:3 are the collision count;
  - bit 15 is the OR of the three error bits;
  - all other bits are 0.
- R7: With the chained flag set, the next descriptor address is word 3, even when end-of-ring is also set.
- R8: Without chaining, the end-of-ring flag (word 1 bit 25) sends the next fetch to the ring base. Otherwise the next fetch is at the current address plus 16.
- R9: A write-back of a descriptor whose word 1 bit 31 is set raises `irq` from the next cycle. `irq_clr` clears it, and a set in the same cycle wins. A descriptor without that bit leaves `irq` unchanged.
- R10: A `cfg_base_we` write takes effect only while the engine is stopped. While the engine is running or suspended, the write is ignored.
- R11: Dropping `cfg_run` lets the descriptor in progress complete its write-back, after which no further fetch happens. The next start begins again at the ring base.
- R12: Mover requests and write-backs follow descriptor traversal order, one frame at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_run | input | 1 | Run (1) / stop (0) control |
| cfg_poll | input | 1 | Poll-demand strobe |
| cfg_base_we | input | 1 | Ring base write strobe |
| cfg_base | input | 32 | Ring base address |
| irq_clr | input | 1 | Write-1 clear of the transmit interrupt |
| unavail_clr | input | 1 | Write-1 clear of buffer-unavailable |
| irq | output | 1 | Transmit interrupt status |
| buf_unavail | output | 1 | Buffer-unavailable status |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory request accepted |
| mv_valid | output | 1 | Transfer request to data mover |
| mv_ready | input | 1 | Data mover accepts request |
| mv_addr | output | 32 | Buffer address |
| mv_len | output | 11 | Buffer byte count |
| mv_first | output | 1 | First segment of frame |
| mv_last | output | 1 | Last segment of frame |
| mv_csum | output | 2 | Checksum insertion control |
| mv_no_crc | output | 1 | Suppress CRC append |
| cpl_valid | input | 1 | Completion report strobe |
| cpl_underflow | input | 1 | Completion: underflow |
| cpl_late_col | input | 1 | Completion: late collision |
| cpl_exc_col | input | 1 | Completion: excessive collision |
| cpl_col_cnt | input | 4 | Completion: collision count |

## Verification
The bench steers the walk with several descriptor layouts:
- a linear ring that wraps on end-of-ring, which separates the wrap from the increment;
- a chained list whose link jumps backwards and whose middle entry also carries end-of-ring, which shows that the link takes priority;
- descriptors left with software, which separate suspend and poll re-fetch from normal progress.

A behavioural memory and a data-mover stub with random ack and completion latency check every transfer and every write-back against queues predicted from the descriptor contents. They also compare the interrupt and unavailable flags on every clock. Base writes while running, and a stop issued during a transfer while the next descriptor is already owned, show whether the engine restarts at the base or continues at its current address.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int DESC_WORDS = 4;
    localparam int DESC_BYTES = WORD_BYTES * DESC_WORDS;
    localparam int LEN_W      = 11;
    localparam int CCNT_W     = 4;
    localparam int OWN_POS    = 31;
    localparam int CTL_LSB    = 24;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        ST_STOP,
        ST_RD0,
        ST_RD1,
        ST_RD2,
        ST_RD3,
        ST_SUSP,
        ST_MOVE,
        ST_WAIT,
        ST_WB,
        ST_NEXT
    } eng_state_t;

    // Decoded control word (word 1)
    typedef struct packed {
        logic             ioc;
        logic             last;
        logic             first;
        logic [1:0]       csum;
        logic             no_crc;
        logic             eor;
        logic             chain;
        logic [LEN_W-1:0] len;
    } ctl_t;

    // Completion report from the data mover
    typedef struct packed {
        logic              underflow;
        logic              late_col;
        logic              exc_col;
        logic [CCNT_W-1:0] col_cnt;
    } cpl_t;

    function automatic ctl_t decode_ctl(input logic [7:0] flags,
                                        input logic [LEN_W-1:0] len);
        ctl_t c;
        c.ioc    = flags[7];
        c.last   = flags[6];
        c.first  = flags[5];
        c.csum   = flags[4:3];
        c.no_crc = flags[2];
        c.eor    = flags[1];
        c.chain  = flags[0];
        c.len    = len;
        return c;
    endfunction

    function automatic word_t pack_status(input cpl_t s);
        word_t w;
        w      = '0;
        w[15]  = s.underflow | s.late_col | s.exc_col;
        w[9]   = s.late_col;
        w[8]   = s.exc_col;
        w[6:3] = s.col_cnt;
        w[1]   = s.underflow;
        return w;
    endfunction

    function automatic word_t next_desc(input word_t cur, input word_t base,
                                        input word_t link, input ctl_t c);
        if (c.chain)
            return link;
        else if (c.eor)
            return base;
        else
            return cur + word_t'(DESC_BYTES);
    endfunction

endpackage

// File: rtl/txr_base.sv
module txr_base
    import txr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  base_we,
    input  word_t base_wdata,
    input  logic  stopped,
    output word_t base_q
);

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (base_we && stopped)
            base_q <= base_wdata;
    end

    // Base never moves while the walker is active
    assert_base_locked_R10: assert property (@(posedge clk) disable iff (rst)
        !stopped |=> base_q == $past(base_q));

endmodule

// File: rtl/txr_status.sv
module txr_status (
    input  logic clk,
    input  logic rst,
    input  logic wb_ioc,
    input  logic susp_event,
    input  logic irq_clr,
    input  logic unavail_clr,
    output logic irq,
    output logic buf_unavail
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq         <= 1'b0;
            buf_unavail <= 1'b0;
        end else begin
            if (wb_ioc)
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
            if (susp_event)
                buf_unavail <= 1'b1;
            else if (unavail_clr)
                buf_unavail <= 1'b0;
        end
    end

    assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
        wb_ioc |=> irq);

    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !wb_ioc) |=> !irq);

    assert_unavail_set_R3: assert property (@(posedge clk) disable iff (rst)
        susp_event |=> buf_unavail);

endmodule

// File: rtl/txr_walker.sv
module txr_walker
    import txr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             poll,
    input  word_t            base,
    output logic             stopped,
    output logic             mem_req,
    output logic             mem_we,
    output word_t            mem_addr,
    output word_t            mem_wdata,
    input  word_t            mem_rdata,
    input  logic             mem_ack,
    output logic             mv_valid,
    input  logic             mv_ready,
    output word_t            mv_addr,
    output logic [LEN_W-1:0] mv_len,
    output logic             mv_first,
    output logic             mv_last,
    output logic [1:0]       mv_csum,
    output logic             mv_no_crc,
    input  logic             cpl_valid,
    input  cpl_t             cpl,
    output logic             wb_ioc,
    output logic             susp_event
);

    eng_state_t state;
    word_t      cur;
    word_t      buf_ptr;
    word_t      link;
    ctl_t       ctl_r;
    cpl_t       cpl_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_STOP;
            cur     <= '0;
            buf_ptr <= '0;
            link    <= '0;
            ctl_r   <= '0;
            cpl_r   <= '0;
        end else begin
            unique case (state)
                ST_STOP: if (run) begin
                    cur   <= base;
                    state <= ST_RD0;
                end
                ST_RD0: if (mem_ack)
                    state <= mem_rdata[OWN_POS] ? ST_RD1 : ST_SUSP;
                ST_RD1: if (mem_ack) begin
                    ctl_r <= decode_ctl(mem_rdata[WORD_W-1:CTL_LSB], mem_rdata[LEN_W-1:0]);
                    state <= ST_RD2;
                end
                ST_RD2: if (mem_ack) begin
                    buf_ptr <= mem_rdata;
                    state   <= ctl_r.chain ? ST_RD3 : ST_MOVE;
                end
                ST_RD3: if (mem_ack) begin
                    link  <= mem_rdata;
                    state <= ST_MOVE;
                end
                ST_SUSP: if (!run)
                    state <= ST_STOP;
                else if (poll)
                    state <= ST_RD0;
                ST_MOVE: if (mv_ready)
                    state <= ST_WAIT;
                ST_WAIT: if (cpl_valid) begin
                    cpl_r <= cpl;
                    state <= ST_WB;
                end
                ST_WB: if (mem_ack) begin
                    cur   <= next_desc(cur, base, link, ctl_r);
                    state <= ST_NEXT;
                end
                ST_NEXT: state <= run ? ST_RD0 : ST_STOP;
                default: state <= ST_STOP;
            endcase
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = cur;
        unique case (state)
            ST_RD0: mem_req = 1'b1;
            ST_RD1: begin mem_req = 1'b1; mem_addr = cur + word_t'(WORD_BYTES);     end
            ST_RD2: begin mem_req = 1'b1; mem_addr = cur + word_t'(2 * WORD_BYTES); end
            ST_RD3: begin mem_req = 1'b1; mem_addr = cur + word_t'(3 * WORD_BYTES); end
            ST_WB:  begin mem_req = 1'b1; mem_we   = 1'b1;                          end
            default: ;
        endcase
    end

    assign mem_wdata  = pack_status(cpl_r);
    assign stopped    = (state == ST_STOP);
    assign mv_valid   = (state == ST_MOVE);
    assign mv_addr    = buf_ptr;
    assign mv_len     = ctl_r.len;
    assign mv_first   = ctl_r.first;
    assign mv_last    = ctl_r.last;
    assign mv_csum    = ctl_r.csum;
    assign mv_no_crc  = ctl_r.no_crc;
    assign wb_ioc     = (state == ST_WB) && mem_ack && ctl_r.ioc;
    assign susp_event = (state == ST_RD0) && mem_ack && !mem_rdata[OWN_POS];

    assert_mem_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_mv_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_addr) && $stable(mv_len)));

    assert_wb_release_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[OWN_POS]);

    assert_no_overlap_R12: assert property (@(posedge clk) disable iff (rst)
        !(mv_valid && mem_req));

endmodule

// File: rtl/txdesc_ring_engine.sv
module txdesc_ring_engine
    import txr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_run,
    input  logic             cfg_poll,
    input  logic             cfg_base_we,
    input  logic [31:0]      cfg_base,
    input  logic             irq_clr,
    input  logic             unavail_clr,
    output logic             irq,
    output logic             buf_unavail,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    output logic             mv_valid,
    input  logic             mv_ready,
    output logic [31:0]      mv_addr,
    output logic [10:0]      mv_len,
    output logic             mv_first,
    output logic             mv_last,
    output logic [1:0]       mv_csum,
    output logic             mv_no_crc,
    input  logic             cpl_valid,
    input  logic             cpl_underflow,
    input  logic             cpl_late_col,
    input  logic             cpl_exc_col,
    input  logic [3:0]       cpl_col_cnt
);

    word_t base_q;
    logic  stopped;
    logic  wb_ioc;
    logic  susp_event;
    cpl_t  cpl_in;

    assign cpl_in.underflow = cpl_underflow;
    assign cpl_in.late_col  = cpl_late_col;
    assign cpl_in.exc_col   = cpl_exc_col;
    assign cpl_in.col_cnt   = cpl_col_cnt;

    txr_base u_base (
        .clk        (clk),
        .rst        (rst),
        .base_we    (cfg_base_we),
        .base_wdata (cfg_base),
        .stopped    (stopped),
        .base_q     (base_q)
    );

    txr_walker u_walker (
        .clk        (clk),
        .rst        (rst),
        .run        (cfg_run),
        .poll       (cfg_poll),
        .base       (base_q),
        .stopped    (stopped),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .mv_valid   (mv_valid),
        .mv_ready   (mv_ready),
        .mv_addr    (mv_addr),
        .mv_len     (mv_len),
        .mv_first   (mv_first),
        .mv_last    (mv_last),
        .mv_csum    (mv_csum),
        .mv_no_crc  (mv_no_crc),
        .cpl_valid  (cpl_valid),
        .cpl        (cpl_in),
        .wb_ioc     (wb_ioc),
        .susp_event (susp_event)
    );

    txr_status u_status (
        .clk         (clk),
        .rst         (rst),
        .wb_ioc      (wb_ioc),
        .susp_event  (susp_event),
        .irq_clr     (irq_clr),
        .unavail_clr (unavail_clr),
        .irq         (irq),
        .buf_unavail (buf_unavail)
    );

    // Stopped engine touches neither memory nor the mover
    assert_stop_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (stopped && !cfg_run) |=> (!mv_valid && (!mem_req || !$past(stopped))));

endmodule

// File: tb/txdesc_ring_engine_test.sv
module txdesc_ring_engine_test;

    localparam int CLK_PERIOD = 10;

    logic        clk, rst;
    logic        cfg_run, cfg_poll, cfg_base_we, irq_clr, unavail_clr;
    logic [31:0] cfg_base;
    logic        irq, buf_unavail;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mv_valid, mv_ready, mv_first, mv_last, mv_no_crc;
    logic [31:0] mv_addr;
    logic [10:0] mv_len;
    logic [1:0]  mv_csum;
    logic        cpl_valid, cpl_underflow, cpl_late_col, cpl_exc_col;
    logic [3:0]  cpl_col_cnt;

    txdesc_ring_engine uut (.*);

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] mem [0:255];
    logic [31:0] rd_log [$];
    logic [31:0] exp_log [$];
    logic [31:0] exp_desc_q [$];
    logic [31:0] wb_addr_q [$];
    logic [31:0] wb_data_q [$];
    bit          wb_ioc_q [$];
    logic [31:0] pend_desc;
    bit          busy;
    int          lat;
    bit          model_irq, model_unav;

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_status(input bit uf, input bit lc,
                                               input bit ec, input logic [3:0] cc);
        logic [31:0] w;
        w      = '0;
        w[15]  = uf | lc | ec;
        w[9]   = lc;
        w[8]   = ec;
        w[6:3] = cc;
        w[1]   = uf;
        return w;
    endfunction

    // Memory, mover stub and per-cycle flag model
    initial begin
        mem_ack = 0; mem_rdata = 0; mv_ready = 0; cpl_valid = 0;
        cpl_underflow = 0; cpl_late_col = 0; cpl_exc_col = 0; cpl_col_cnt = 0;
        busy = 0; lat = 0; model_irq = 0; model_unav = 0; pend_desc = 0;
        forever begin
            @(negedge clk); #1;
            if (!rst) begin
                chk(irq == model_irq, "R9 irq flag", 32'(irq), 32'(model_irq));
                chk(buf_unavail == model_unav, "R3 unavailable flag",
                    32'(buf_unavail), 32'(model_unav));
            end
            mem_ack = 0; mv_ready = 0; cpl_valid = 0;
            if (!rst) begin
                if (irq_clr) model_irq = 0;
                if (unavail_clr) model_unav = 0;
                if (mem_req && ($urandom % 4) != 0) begin
                    mem_ack = 1;
                    if (mem_we) begin
                        if (wb_addr_q.size() == 0) begin
                            chk(0, "R12 unexpected write-back", mem_addr, 0);
                        end else begin
                            chk(mem_addr == wb_addr_q[0], "R12 write-back order",
                                mem_addr, wb_addr_q[0]);
                            chk(mem_wdata == wb_data_q[0], "R6 write-back word",
                                mem_wdata, wb_data_q[0]);
                            if (wb_ioc_q[0]) model_irq = 1;
                            void'(wb_addr_q.pop_front());
                            void'(wb_data_q.pop_front());
                            void'(wb_ioc_q.pop_front());
                        end
                        mem[mem_addr[9:2]] = mem_wdata;
                    end else begin
                        mem_rdata = mem[mem_addr[9:2]];
                        rd_log.push_back(mem_addr);
                        if (mem_addr[3:0] == 4'h0 && !mem_rdata[31]) model_unav = 1;
                    end
                end
                if (busy) begin
                    if (lat <= 1) begin
                        cpl_valid     = 1;
                        cpl_underflow = 1'($urandom);
                        cpl_late_col  = 1'($urandom);
                        cpl_exc_col   = 1'($urandom);
                        cpl_col_cnt   = 4'($urandom);
                        wb_addr_q.push_back(pend_desc);
                        wb_data_q.push_back(ref_status(cpl_underflow, cpl_late_col,
                                                       cpl_exc_col, cpl_col_cnt));
                        wb_ioc_q.push_back(mem[pend_desc[9:2] + 8'd1][31]);
                        busy = 0;
                    end else begin
                        lat--;
                    end
                end else if (mv_valid && ($urandom % 3) != 0) begin
                    mv_ready = 1;
                    if (exp_desc_q.size() == 0) begin
                        chk(0, "R12 unexpected transfer", mv_addr, 0);
                        pend_desc = 0;
                    end else begin
                        logic [31:0] a, w1;
                        a  = exp_desc_q.pop_front();
                        w1 = mem[a[9:2] + 8'd1];
                        chk(mv_addr == mem[a[9:2] + 8'd2], "R5 buffer address",
                            mv_addr, mem[a[9:2] + 8'd2]);
                        chk(mv_len == w1[10:0], "R5 length", 32'(mv_len), 32'(w1[10:0]));
                        chk({mv_first, mv_last, mv_csum, mv_no_crc} ==
                            {w1[29], w1[30], w1[28:27], w1[26]}, "R5 flags",
                            32'({mv_first, mv_last, mv_csum, mv_no_crc}),
                            32'({w1[29], w1[30], w1[28:27], w1[26]}));
                        pend_desc = a;
                    end
                    busy = 1;
                    lat  = 1 + int'($urandom % 8);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_desc(input logic [31:0] a, input logic [31:0] w0,
                            input logic [31:0] w1, input logic [31:0] w2,
                            input logic [31:0] w3);
        mem[a[9:2]]        = w0;
        mem[a[9:2] + 8'd1] = w1;
        mem[a[9:2] + 8'd2] = w2;
        mem[a[9:2] + 8'd3] = w3;
    endtask

    task automatic chk_log(input string req);
        chk(rd_log.size() == exp_log.size(), req, 32'(rd_log.size()), 32'(exp_log.size()));
        for (int i = 0; i < exp_log.size() && i < rd_log.size(); i++)
            chk(rd_log[i] == exp_log[i], req, rd_log[i], exp_log[i]);
    endtask

    task automatic wait_unavail(input string req);
        int n;
        n = 0;
        while (!buf_unavail && n < 3000) begin
            tick(1);
            n++;
        end
        chk(buf_unavail, req, 32'(buf_unavail), 1);
    endtask

    task automatic pulse_irq_clr();
        irq_clr = 1; tick(1); irq_clr = 0;
    endtask

    task automatic pulse_unav_clr();
        unavail_clr = 1; tick(1); unavail_clr = 0;
    endtask

    task automatic pulse_poll();
        cfg_poll = 1; tick(1); cfg_poll = 0;
    endtask

    task automatic write_base(input logic [31:0] b);
        cfg_base = b; cfg_base_we = 1; tick(1); cfg_base_we = 0;
    endtask

    initial begin
        rst = 1; cfg_run = 0; cfg_poll = 0; cfg_base_we = 0; cfg_base = 0;
        irq_clr = 0; unavail_clr = 0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        tick(3);
        rst = 0;
        tick(1);
        // R1: reset state
        chk(!mem_req && !mv_valid, "R1 idle ports", 32'({mem_req, mv_valid}), 0);
        chk(!irq && !buf_unavail, "R1 flags clear", 32'({irq, buf_unavail}), 0);

        // Linear ring, wrap on end-of-ring (R2, R8)
        set_desc(32'h100, 32'h8000_0000, 32'h6000_003C, 32'h0000_1000, 32'h0000_03F0);
        set_desc(32'h110, 32'h8000_0000, 32'h2000_05EA, 32'h0000_2000, 32'h0000_03F0);
        set_desc(32'h120, 32'h8000_0000, 32'hDE00_0040, 32'h0000_3000, 32'h0000_03F0);
        write_base(32'h100);
        exp_desc_q = '{32'h100, 32'h110, 32'h120};
        cfg_run = 1;
        wait_unavail("R3 suspend on unowned");
        exp_log = '{32'h100, 32'h104, 32'h108, 32'h110, 32'h114, 32'h118,
                    32'h120, 32'h124, 32'h128, 32'h100};
        chk_log("R2 R8 fetch order with wrap");
        tick(20);
        chk(rd_log.size() == 10, "R3 no fetch while suspended", 32'(rd_log.size()), 10);
        chk(irq, "R9 interrupt after flagged descriptor", 32'(irq), 1);
        pulse_irq_clr();
        tick(1);
        chk(!irq, "R9 write-1 clear", 32'(irq), 0);
        pulse_unav_clr();
        tick(1);
        chk(!buf_unavail, "R3 write-1 clear", 32'(buf_unavail), 0);

        // Poll re-fetches the same descriptor (R4)
        rd_log.delete();
        pulse_poll();
        wait_unavail("R4 suspend again");
        exp_log = '{32'h100};
        chk_log("R4 poll re-fetch");
        pulse_unav_clr();

        // Hand back two descriptors, resume by poll (R4, R8 increment, R9 no ioc)
        mem[32'h100 >> 2] = 32'h8000_0000;
        mem[32'h110 >> 2] = 32'h8000_0000;
        exp_desc_q = '{32'h100, 32'h110};
        rd_log.delete();
        pulse_poll();
        wait_unavail("R4 resume then suspend");
        exp_log = '{32'h100, 32'h104, 32'h108, 32'h110, 32'h114, 32'h118, 32'h120};
        chk_log("R8 step by 16");
        chk(!irq, "R9 no interrupt without flag", 32'(irq), 0);
        pulse_unav_clr();

        // Base write while running is ignored (R10)
        write_base(32'h380);
        cfg_run = 0;
        tick(5);
        rd_log.delete();
        cfg_run = 1;
        wait_unavail("R10 restart suspends");
        chk(rd_log.size() > 0 && rd_log[0] == 32'h100, "R10 base kept while running",
            rd_log.size() > 0 ? rd_log[0] : 32'hFFFF_FFFF, 32'h100);
        pulse_unav_clr();
        cfg_run = 0;
        tick(5);

        // Chained list, link wins over end-of-ring (R7, R10 accepted when stopped)
        write_base(32'h200);
        set_desc(32'h200, 32'h8000_0000, 32'h6100_0064, 32'h0000_4000, 32'h0000_0300);
        set_desc(32'h300, 32'h8000_0000, 32'h2300_0020, 32'h0000_5000, 32'h0000_0240);
        set_desc(32'h240, 32'h8000_0000, 32'hC100_00C8, 32'h0000_6000, 32'h0000_0200);
        exp_desc_q = '{32'h200, 32'h300, 32'h240};
        rd_log.delete();
        cfg_run = 1;
        wait_unavail("R7 chain ends at unowned");
        exp_log = '{32'h200, 32'h204, 32'h208, 32'h20C, 32'h300, 32'h304, 32'h308,
                    32'h30C, 32'h240, 32'h244, 32'h248, 32'h24C, 32'h200};
        chk_log("R7 chained order");
        chk(irq, "R9 interrupt on chained", 32'(irq), 1);
        pulse_irq_clr();
        pulse_unav_clr();

        // Stop during a transfer with the next entry owned (R11)
        mem[32'h200 >> 2] = 32'h8000_0000;
        mem[32'h300 >> 2] = 32'h8000_0000;
        exp_desc_q = '{32'h200};
        rd_log.delete();
        pulse_poll();
        for (int n = 0; n < 3000 && exp_desc_q.size() != 0; n++) tick(1);
        cfg_run = 0;
        tick(40);
        chk(rd_log.size() == 4, "R11 no fetch after stop", 32'(rd_log.size()), 4);
        chk(!mem[32'h200 >> 2][31], "R11 frame finished", mem[32'h200 >> 2], 0);
        chk(wb_addr_q.size() == 0, "R12 write-back done", 32'(wb_addr_q.size()), 0);
        rd_log.delete();
        cfg_run = 1;
        wait_unavail("R11 restart suspends");
        chk(rd_log.size() > 0 && rd_log[0] == 32'h200, "R11 restart at base",
            rd_log.size() > 0 ? rd_log[0] : 32'hFFFF_FFFF, 32'h200);
        cfg_run = 0;
        tick(10);
        chk(exp_desc_q.size() == 0 && !busy, "R12 all transfers seen",
            32'(exp_desc_q.size()), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd100000, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule